// File: doc/BRIEF.md
# Ring-Coupled PWM Edge Synthesizer

This block turns the A and B pulse-width signals of a ring of PWM channels into new waveforms. Each channel has two outputs. Each output is a set/reset latch. One selectable event sets it and another selectable event clears it. There are four edges per channel: rising A, falling A, rising B and falling B. Each edge picks one of eight events. The candidate events are the edges of the channel's own A and B inputs and the edges of the A and B inputs of the next channel in the ring. The ring wraps, so the last channel uses channel 0 as its neighbour.

Each channel also builds a C signal from two blanking strobes. The blanking-B start strobe sets it and the blanking-B end strobe clears it. When the block is built with `USE_C` set, the two highest event codes take the edges of the channel's own C signal instead of the neighbour's B edges.

A small write port loads the edge selections and the enable bit of one channel at a time. New selections wait in a pending register. They take effect only on a period-start strobe, so a PWM period is never built from a mix of old and new selections. The enable bit takes effect at once. While a channel is disabled, its outputs are held low and its latches are cleared.

Top module: `ring_edge_synth`

## Requirements
- R1: While `rst_n` is low, and after it is released until a channel is configured, all `out_a`, `out_b` and `pwm_c` bits are 0, every channel is disabled and all selections are code 0.
- R2: Edge detection compares each A or B input with its value one clock earlier. An input edge seen at a rising clock edge changes the selected output at that same clock edge, so the output moves one cycle after the input. The event codes are: 0 own A rising, 1 own A falling, 2 own B rising, 3 own B falling, 4 next A rising, 5 next A falling, 6 next B rising, 7 next B falling.
- R3: The next channel of channel i is channel (i+1) mod NCH, so channel NCH-1 takes its neighbour events from channel 0.
- R4: On an enabled channel, the rise selection's event sets the output and the fall selection's event clears it. With neither event present, the output holds its value.
- R5: When the set event and the clear event of an output occur in the same cycle, the output is cleared. A channel whose rise and fall selections are equal therefore keeps that output low.
- R6: A write goes to the channel's pending selections. The active selections copy the pending ones only in a cycle with `period_start` high. A write made in that same cycle reaches the active set only at the next `period_start`.
- R7: A write sets the channel's enable from `cfg_en` in the following cycle. While the enable is 0, both outputs are forced low from the next clock edge onward, and input edges cannot set them.
- R8: `pwm_c[i]` rises one cycle after `blank_b_start[i]` and falls one cycle after `blank_b_end[i]`. If both strobes arrive in the same cycle, the end strobe wins.
- R9: With `USE_C` = 1, codes 6 and 7 select the rising and falling edges of the channel's own C signal. An output set by the C rising edge goes high two cycles after the start strobe.
- R10: `cfg_sel` packs the selections as bits [2:0] rising A, [5:3] falling A, [8:6] rising B and [11:9] falling B. A write changes only the channel named by `cfg_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_a | input | NCH | A inputs of all channels |
| pwm_b | input | NCH | B inputs of all channels |
| blank_b_start | input | NCH | Blanking-B start strobes |
| blank_b_end | input | NCH | Blanking-B end strobes |
| period_start | input | 1 | Loads pending selections into the active set |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 4*SELW | Packed edge selections |
| cfg_en | input | 1 | Enable value written to the channel |
| out_a | output | NCH | Synthesized A outputs |
| out_b | output | NCH | Synthesized B outputs |
| pwm_c | output | NCH | C signal of each channel |

## Verification
The bench builds the block with four channels and `USE_C` = 1. With this build the ring wrap from channel 3 to channel 0 can be observed. The C signal also becomes an event source, so the two-cycle path from a blanking strobe to an output is exercised along with the direct A and B edge paths. Because codes 6 and 7 map to C, this build does not reach the neighbour's B edges. Each channel gets different selections, which covers same-cycle set/clear conflicts, selections deferred across a period boundary, and disabling a channel while its output is high.

// File: rtl/ring_edge_synth.sv
module ring_edge_synth #(
  parameter int NCH   = 4,
  parameter int USE_C = 1,
  localparam int NEV  = 8,
  localparam int SELW = $clog2(NEV),
  localparam int CFGW = 4 * SELW,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pwm_a,
  input  logic [NCH-1:0]  pwm_b,
  input  logic [NCH-1:0]  blank_b_start,
  input  logic [NCH-1:0]  blank_b_end,
  input  logic            period_start,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [CFGW-1:0] cfg_sel,
  input  logic            cfg_en,
  output logic [NCH-1:0]  out_a,
  output logic [NCH-1:0]  out_b,
  output logic [NCH-1:0]  pwm_c
);

  logic [NCH-1:0] a_q, b_q, c_q, c_prev, en_q, oa_q, ob_q;
  logic [CFGW-1:0] pend_q [NCH];
  logic [CFGW-1:0] act_q  [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      c_prev <= '0;
    end else begin
      a_q    <= pwm_a;
      b_q    <= pwm_b;
      c_prev <= c_q;
    end
  end

  assign out_a = oa_q;
  assign out_b = ob_q;
  assign pwm_c = c_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int NX = (i + 1) % NCH;
    logic [NEV-1:0] ev;
    logic set_a, clr_a, set_b, clr_b, wr;

    assign wr = cfg_we && (cfg_ch == CHW'(i));

    assign ev[0] =  pwm_a[i]  & ~a_q[i];
    assign ev[1] = ~pwm_a[i]  &  a_q[i];
    assign ev[2] =  pwm_b[i]  & ~b_q[i];
    assign ev[3] = ~pwm_b[i]  &  b_q[i];
    assign ev[4] =  pwm_a[NX] & ~a_q[NX];
    assign ev[5] = ~pwm_a[NX] &  a_q[NX];

    if (USE_C != 0) begin : g_csrc
      assign ev[6] =  c_q[i] & ~c_prev[i];
      assign ev[7] = ~c_q[i] &  c_prev[i];
    end else begin : g_bsrc
      assign ev[6] =  pwm_b[NX] & ~b_q[NX];
      assign ev[7] = ~pwm_b[NX] &  b_q[NX];
    end

    assign set_a = ev[act_q[i][0*SELW +: SELW]];
    assign clr_a = ev[act_q[i][1*SELW +: SELW]];
    assign set_b = ev[act_q[i][2*SELW +: SELW]];
    assign clr_b = ev[act_q[i][3*SELW +: SELW]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= '0;
        act_q[i]  <= '0;
        en_q[i]   <= 1'b0;
        c_q[i]    <= 1'b0;
        oa_q[i]   <= 1'b0;
        ob_q[i]   <= 1'b0;
      end else begin
        if (period_start) act_q[i] <= pend_q[i];
        if (wr) begin
          pend_q[i] <= cfg_sel;
          en_q[i]   <= cfg_en;
        end
        if (blank_b_end[i])        c_q[i] <= 1'b0;
        else if (blank_b_start[i]) c_q[i] <= 1'b1;
        if (!en_q[i])   oa_q[i] <= 1'b0;
        else if (clr_a) oa_q[i] <= 1'b0;
        else if (set_a) oa_q[i] <= 1'b1;
        if (!en_q[i])   ob_q[i] <= 1'b0;
        else if (clr_b) ob_q[i] <= 1'b0;
        else if (set_b) ob_q[i] <= 1'b1;
      end
    end

    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> (!out_a[i] && !out_b[i]));
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && clr_a) |=> !out_a[i]);
    a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && set_b && !clr_b) |=> out_b[i]);
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !set_a && !clr_a) |=> $stable(out_a[i]));
    a_r6_sel_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |=> $stable(act_q[i]));
    a_r8_c_end_wins: assert property (@(posedge clk) disable iff (!rst_n)
      blank_b_end[i] |=> !pwm_c[i]);
  end

endmodule

// File: tb/ring_edge_synth_test.sv
module ring_edge_synth_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pa = '0, pb = '0, bs = '0, be = '0;
  logic ps = 1'b0, we = 1'b0, en = 1'b0;
  logic [1:0] ch = '0;
  logic [11:0] sel = '0;
  logic [3:0] out_a, out_b, pwm_c;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  ring_edge_synth #(.NCH(4), .USE_C(1)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_a(pa), .pwm_b(pb),
    .blank_b_start(bs), .blank_b_end(be), .period_start(ps),
    .cfg_we(we), .cfg_ch(ch), .cfg_sel(sel), .cfg_en(en),
    .out_a(out_a), .out_b(out_b), .pwm_c(pwm_c));

  bit [3:0] ma, mb, mc, mcp, men, moa, mob;
  bit [11:0] mpend [4];
  bit [11:0] mact  [4];

  // fields {pa, pb, bs, be, ps}
  localparam logic [16:0] VEC [16] = '{
    17'h1E1A4, 17'h0A5C3, 17'h15012, 17'h0F1E0, 17'h03A51, 17'h1C0C8,
    17'h0620E, 17'h19F30, 17'h04405, 17'h1B1C2, 17'h07E14, 17'h12A69,
    17'h0D0F0, 17'h1E5A3, 17'h01C1C, 17'h16311 };

  function automatic logic [11:0] mk(int ra, int fa, int rb, int fb);
    return {fb[2:0], rb[2:0], fa[2:0], ra[2:0]};
  endfunction

  function automatic bit evf(int i, bit [2:0] code);
    int n = (i + 1) % 4;
    case (code)
      3'd0: return pa[i] & !ma[i];
      3'd1: return !pa[i] & ma[i];
      3'd2: return pb[i] & !mb[i];
      3'd3: return !pb[i] & mb[i];
      3'd4: return pa[n] & !ma[n];
      3'd5: return !pa[n] & ma[n];
      3'd6: return mc[i] & !mcp[i];
      default: return !mc[i] & mcp[i];
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [3:0] a, logic [3:0] b, logic [3:0] s, logic [3:0] e,
                      logic p, logic w = 1'b0, logic [1:0] c = 2'd0, logic [11:0] v = '0,
                      logic n = 1'b0);
    bit [3:0] noa, nob, nc;
    @(negedge clk);
    pa = a; pb = b; bs = s; be = e; ps = p; we = w; ch = c; sel = v; en = n;
    for (int i = 0; i < 4; i++) begin
      bit sa, ca, sb, cb;
      sa = evf(i, mact[i][2:0]);  ca = evf(i, mact[i][5:3]);
      sb = evf(i, mact[i][8:6]);  cb = evf(i, mact[i][11:9]);
      noa[i] = men[i] ? (ca ? 1'b0 : (sa ? 1'b1 : moa[i])) : 1'b0;
      nob[i] = men[i] ? (cb ? 1'b0 : (sb ? 1'b1 : mob[i])) : 1'b0;
      nc[i]  = e[i] ? 1'b0 : (s[i] ? 1'b1 : mc[i]);
    end
    mcp = mc; mc = nc; ma = a; mb = b; moa = noa; mob = nob;
    for (int i = 0; i < 4; i++) begin
      if (p) mact[i] = mpend[i];
      if (w && c == 2'(i)) begin mpend[i] = v; men[i] = n; end
    end
    @(posedge clk); #5;
    check(tag, {out_a, out_b, pwm_c}, {moa, mob, mc});
  endtask

  task automatic cfg(int c, logic [11:0] v, logic n);
    step("R10", pa, pb, 4'h0, 4'h0, 1'b0, 1'b1, 2'(c), v, n);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check("R1 reset", {out_a, out_b, pwm_c}, 12'h000);
    @(negedge clk) rst_n = 1'b1;
    step("R1", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    step("R1 no enable", 4'hF, 4'hF, 4'h0, 4'h0, 1'b1);
    check("R1 idle", {out_a, out_b}, 8'h00);

    cfg(0, mk(0, 1, 2, 3), 1'b1);
    cfg(1, mk(4, 5, 6, 7), 1'b1);
    cfg(2, mk(2, 3, 0, 1), 1'b1);
    cfg(3, mk(4, 0, 6, 2), 1'b1);
    step("R6", 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    foreach (VEC[k])
      step("R2 R4 R8 R9 vector", VEC[k][16:13], VEC[k][12:9], VEC[k][8:5], VEC[k][4:1], VEC[k][0]);

    // R6: pending selection waits for period_start
    step("R4", 4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
    step("R4 clear", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    cfg(0, mk(2, 1, 2, 3), 1'b1);
    step("R6", 4'h0, 4'h1, 4'h0, 4'h0, 1'b0);
    check("R6 old selection kept", {3'b0, out_a[0]}, 4'h0);
    step("R6", 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    step("R6 new selection", 4'h0, 4'h1, 4'h0, 4'h0, 1'b0);
    check("R6 new selection live", {3'b0, out_a[0]}, 4'h1);

    // R5: rise and fall selections equal
    cfg(2, mk(0, 0, 0, 1), 1'b1);
    step("R5", 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    step("R5", 4'h4, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R5 clear priority", {3'b0, out_a[2]}, 4'h0);

    // R3: channel 3 follows channel 0
    cfg(3, mk(4, 5, 6, 7), 1'b1);
    step("R3", 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    step("R3", 4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R3 ring wrap", {3'b0, out_a[3]}, 4'h1);

    // R7: disable forces low
    cfg(3, mk(4, 5, 6, 7), 1'b0);
    step("R7", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R7 disabled low", {3'b0, out_a[3]}, 4'h0);
    step("R7", 4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R7 edge ignored", {3'b0, out_a[3]}, 4'h0);

    // R8 R9: C signal and its events on channel 1
    step("R8", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    step("R8", 4'h0, 4'h0, 4'h2, 4'h0, 1'b0);
    check("R8 c rises", {3'b0, pwm_c[1]}, 4'h1);
    step("R9", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R9 c edge sets out_b", {3'b0, out_b[1]}, 4'h1);
    step("R8", 4'h0, 4'h0, 4'h2, 4'h2, 1'b0);
    check("R8 end wins", {3'b0, pwm_c[1]}, 4'h0);
    step("R9", 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R9 c fall clears out_b", {3'b0, out_b[1]}, 4'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule